// File: doc/BRIEF.md
# Ring Directory Controller with Nearest-Holder Forwarding

This block is the coherence directory for a small group of processors placed on a bidirectional ring, each a single hop from the memory controller that hosts the directory. For every memory block it keeps a coherence state (invalid, shared or modified) and an exact bit vector of the caches that hold the block. Caches report every replacement to the directory, so the vector is always exact. The directory needs no eviction logic because it has room for every block.

A request names the processor, the block and whether the access is a read or a write. It is resolved combinationally in the cycle it is presented. The block does not move messages itself. It emits command vectors for the network:
- which cache must forward the line to the requester;
- which caches must invalidate their copy;
- how many invalidation acknowledgements the requester must collect before it writes;
- whether the line must come from memory.

The supplier is always the holder with the shortest ring distance to the requester. Ring distance is measured the shorter way round the ring. When two holders are equally close, the lower index wins. At the next clock edge the directory entry is updated. A read joins the holder set, and any former owner is downgraded to shared. A write leaves the requester as the only holder, in the modified state.

Top module: `ring_dir_ctrl`

## Requirements
- R1: After reset every block reads back as state invalid (encoding 0) with an all-zero holder vector. This includes a reset applied in the middle of operation.
- R2: A read to a block that no processor other than the requester holds sets mem_rd. It forwards nothing, invalidates nothing and reports an acknowledgement count of 0.
- R3: A read to a block that another processor holds sets exactly one bit of fwd_sel, with bit i meaning processor i, and leaves mem_rd low. The chosen holder is the one with the smallest ring distance, min(|i-r|, N-|i-r|), to requester r. On a tie the lower index is chosen. The requester is never chosen.
- R4: After a read, the block is in state shared (encoding 1) and the requester's bit is added to the holder vector. A previous owner in modified (encoding 2) is downgraded and keeps its bit.
- R5: A write sets inv_vec to the holder vector with the requester's bit cleared, and ack_cnt to the number of bits set in inv_vec. A read leaves inv_vec at zero.
- R6: On a write where the requester already holds the block, there is no forward and no memory fetch. If the requester does not hold it and other holders exist, the nearest of them forwards the line, using the R3 rule. If no cache holds it, mem_rd is set.
- R7: After a write, the block is in state modified (encoding 2) and the holder vector contains only the requester's bit.
- R8: While req_valid is low, fwd_sel, inv_vec, ack_cnt and mem_rd are all zero. The directory is left unchanged, whatever the other request inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is presented this cycle |
| req_proc | input | PID_W (2) | Requesting processor index |
| req_write | input | 1 | 1 = write miss or upgrade, 0 = read miss |
| req_blk | input | BLK_W (4) | Block index |
| fwd_valid | output | 1 | A cache is asked to forward the line |
| fwd_sel | output | NPROC (4) | One-hot forwarding cache, bit i = processor i |
| inv_vec | output | NPROC (4) | Caches to invalidate |
| ack_cnt | output | CNT_W (3) | Acknowledgements the requester must collect |
| mem_rd | output | 1 | Line must be fetched from memory |
| blk_state | output | 2 | Current state of req_blk: 0 invalid, 1 shared, 2 modified |
| blk_sharers | output | NPROC (4) | Current holder vector of req_blk |

## Verification
The assertions check the following every cycle:
- fwd_sel is at most one-hot and never points at the requester;
- a memory fetch and a forward never happen together;
- invalidations appear only on writes, never include the requester, and match the acknowledgement count;
- an idle cycle produces no commands;
- an entry is invalid exactly when its holder vector is empty;
- after a write the entry shows the requester as sole owner, and after a read it shows the requester joined.

Only the bench's scenarios can show that the forwarding cache is really the nearest one and that ties go to the lower index. They also show that an owner is downgraded rather than dropped, that upgrades fetch no data, and that entries for different blocks, including the first and last index, do not disturb one another.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

  typedef enum logic [1:0] {
    ST_INV = 2'd0,
    ST_SHR = 2'd1,
    ST_MOD = 2'd2
  } blk_st_e;

  // shorter way round a ring of n nodes
  function automatic int unsigned ring_hops(int unsigned a, int unsigned b, int unsigned n);
    int unsigned d;
    d = (a > b) ? (a - b) : (b - a);
    return (d > n - d) ? (n - d) : d;
  endfunction

endpackage

// File: rtl/ring_pick.sv
module ring_pick #(
  parameter int NPROC = 4,
  localparam int PID_W = $clog2(NPROC)
) (
  input  logic [PID_W-1:0] origin,
  input  logic [NPROC-1:0] cand,
  output logic [NPROC-1:0] pick
);
  import dirc_pkg::*;

  int unsigned hops [NPROC];

  generate
    for (genvar g = 0; g < NPROC; g++) begin : g_hops
      always_comb hops[g] = ring_hops(int'(origin), g, NPROC);
    end
  endgenerate

  always_comb begin
    int unsigned best;
    pick = '0;
    best = NPROC;
    // ascending scan with strict compare keeps the lower index on a tie
    for (int i = 0; i < NPROC; i++) begin
      if (cand[i] && hops[i] < best) begin
        best = hops[i];
        pick = NPROC'(1) << i;
      end
    end
  end

endmodule

// File: rtl/dir_store.sv
module dir_store #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  localparam int BLK_W = $clog2(NBLK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BLK_W-1:0]     lk_blk,
  output dirc_pkg::blk_st_e    lk_st,
  output logic [NPROC-1:0]     lk_sh,
  input  logic                 upd_en,
  input  logic [BLK_W-1:0]     upd_blk,
  input  dirc_pkg::blk_st_e    upd_st,
  input  logic [NPROC-1:0]     upd_sh
);
  import dirc_pkg::*;

  blk_st_e          st_q [NBLK];
  logic [NPROC-1:0] sh_q [NBLK];
  logic [NBLK-1:0]  wr_hit;

  generate
    for (genvar g = 0; g < NBLK; g++) begin : g_ent
      always_comb wr_hit[g] = upd_en && (upd_blk == BLK_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_q[g] <= ST_INV;
          sh_q[g] <= '0;
        end else if (wr_hit[g]) begin
          st_q[g] <= upd_st;
          sh_q[g] <= upd_sh;
        end
      end
    end
  endgenerate

  always_comb begin
    lk_st = st_q[lk_blk];
    lk_sh = sh_q[lk_blk];
  end

endmodule

// File: rtl/dir_decide.sv
module dir_decide #(
  parameter int NPROC = 4,
  localparam int PID_W = $clog2(NPROC),
  localparam int CNT_W = $clog2(NPROC + 1)
) (
  input  logic               req_valid,
  input  logic [PID_W-1:0]   req_proc,
  input  logic               req_write,
  input  logic [NPROC-1:0]   lk_sh,
  output logic [NPROC-1:0]   fwd_sel,
  output logic [NPROC-1:0]   inv_vec,
  output logic [CNT_W-1:0]   ack_cnt,
  output logic               mem_rd,
  output logic               upd_en,
  output dirc_pkg::blk_st_e  new_st,
  output logic [NPROC-1:0]   new_sh
);
  import dirc_pkg::*;

  logic [NPROC-1:0] req_oh;
  logic [NPROC-1:0] others;
  logic [NPROC-1:0] nearest;
  logic             self_holds;
  logic             need_data;

  ring_pick #(.NPROC(NPROC)) u_pick (
    .origin (req_proc),
    .cand   (others),
    .pick   (nearest)
  );

  always_comb begin
    req_oh     = NPROC'(1) << req_proc;
    others     = lk_sh & ~req_oh;
    self_holds = |(lk_sh & req_oh);
    need_data  = !req_write || !self_holds;

    fwd_sel = (req_valid && need_data && |others) ? nearest : '0;
    mem_rd  = req_valid && need_data && !(|others);
    inv_vec = (req_valid && req_write) ? others : '0;

    ack_cnt = '0;
    for (int i = 0; i < NPROC; i++) begin
      ack_cnt = ack_cnt + CNT_W'(inv_vec[i]);
    end

    upd_en = req_valid;
    new_st = req_write ? ST_MOD : ST_SHR;
    new_sh = req_write ? req_oh : (lk_sh | req_oh);
  end

endmodule

// File: rtl/ring_dir_ctrl.sv
module ring_dir_ctrl #(
  parameter int NPROC = 4,
  parameter int NBLK  = 16,
  localparam int PID_W = $clog2(NPROC),
  localparam int BLK_W = $clog2(NBLK),
  localparam int CNT_W = $clog2(NPROC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [PID_W-1:0] req_proc,
  input  logic             req_write,
  input  logic [BLK_W-1:0] req_blk,
  output logic             fwd_valid,
  output logic [NPROC-1:0] fwd_sel,
  output logic [NPROC-1:0] inv_vec,
  output logic [CNT_W-1:0] ack_cnt,
  output logic             mem_rd,
  output logic [1:0]       blk_state,
  output logic [NPROC-1:0] blk_sharers
);
  import dirc_pkg::*;

  logic [1:0]       rsync_q;
  logic             rst_sync_n;
  blk_st_e          lk_st;
  logic [NPROC-1:0] lk_sh;
  logic             upd_en;
  blk_st_e          new_st;
  logic [NPROC-1:0] new_sh;
  logic [NPROC-1:0] req_oh;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  dir_store #(.NPROC(NPROC), .NBLK(NBLK)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lk_blk  (req_blk),
    .lk_st   (lk_st),
    .lk_sh   (lk_sh),
    .upd_en  (upd_en),
    .upd_blk (req_blk),
    .upd_st  (new_st),
    .upd_sh  (new_sh)
  );

  dir_decide #(.NPROC(NPROC)) u_dec (
    .req_valid (req_valid),
    .req_proc  (req_proc),
    .req_write (req_write),
    .lk_sh     (lk_sh),
    .fwd_sel   (fwd_sel),
    .inv_vec   (inv_vec),
    .ack_cnt   (ack_cnt),
    .mem_rd    (mem_rd),
    .upd_en    (upd_en),
    .new_st    (new_st),
    .new_sh    (new_sh)
  );

  assign fwd_valid   = |fwd_sel;
  assign blk_state   = lk_st;
  assign blk_sharers = lk_sh;
  assign req_oh      = NPROC'(1) << req_proc;

  AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(fwd_sel)); // R3
  AST_FWD_NOT_SELF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fwd_sel & req_oh) == '0); // R3
  AST_MEM_OR_FWD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mem_rd && fwd_valid)); // R6
  AST_INV_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!req_write |-> inv_vec == '0) and ((inv_vec & req_oh) == '0)); // R5
  AST_ACK_MATCH: assert property (@(posedge clk) disable iff (!rst_sync_n)
    int'(ack_cnt) == $countones(inv_vec)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |-> (fwd_sel == '0 && inv_vec == '0 && ack_cnt == '0 && !mem_rd)); // R8
  AST_HOLDER_CONSIST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (blk_state == 2'(ST_INV)) == (blk_sharers == '0)); // R4
  AST_WRITE_OWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(req_valid && req_write) && req_blk == $past(req_blk))
    |-> (blk_state == 2'(ST_MOD) && blk_sharers == $past(req_oh))); // R7
  AST_READ_JOIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && $past(req_valid && !req_write) && req_blk == $past(req_blk))
    |-> (blk_state == 2'(ST_SHR) && (blk_sharers & $past(req_oh)) != '0)); // R4

endmodule

// File: tb/sim_ring_dir_ctrl.sv
module sim_ring_dir_ctrl;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic [1:0] req_proc;
  logic       req_write;
  logic [3:0] req_blk;
  logic       fwd_valid;
  logic [3:0] fwd_sel;
  logic [3:0] inv_vec;
  logic [2:0] ack_cnt;
  logic       mem_rd;
  logic [1:0] blk_state;
  logic [3:0] blk_sharers;

  int total = 0;
  int bad   = 0;

  ring_dir_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_proc(req_proc),
    .req_write(req_write), .req_blk(req_blk), .fwd_valid(fwd_valid),
    .fwd_sel(fwd_sel), .inv_vec(inv_vec), .ack_cnt(ack_cnt), .mem_rd(mem_rd),
    .blk_state(blk_state), .blk_sharers(blk_sharers)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // fields: proc[24:23] wr[22] blk[21:18] fwd[17:14] inv[13:10] ack[9:7] mem[6] st[5:4] sh[3:0]
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 1'b0, 4'd1,  4'b0000, 4'b0000, 3'd0, 1'b1, 2'd0, 4'b0000},
    {2'd2, 1'b0, 4'd1,  4'b0001, 4'b0000, 3'd0, 1'b0, 2'd1, 4'b0001},
    {2'd1, 1'b0, 4'd1,  4'b0001, 4'b0000, 3'd0, 1'b0, 2'd1, 4'b0101},
    {2'd3, 1'b1, 4'd1,  4'b0001, 4'b0111, 3'd3, 1'b0, 2'd1, 4'b0111},
    {2'd1, 1'b0, 4'd1,  4'b1000, 4'b0000, 3'd0, 1'b0, 2'd2, 4'b1000},
    {2'd1, 1'b1, 4'd1,  4'b0000, 4'b1000, 3'd1, 1'b0, 2'd1, 4'b1010},
    {2'd1, 1'b1, 4'd1,  4'b0000, 4'b0000, 3'd0, 1'b0, 2'd2, 4'b0010},
    {2'd3, 1'b1, 4'd2,  4'b0000, 4'b0000, 3'd0, 1'b1, 2'd0, 4'b0000},
    {2'd2, 1'b0, 4'd2,  4'b1000, 4'b0000, 3'd0, 1'b0, 2'd2, 4'b1000},
    {2'd0, 1'b0, 4'd2,  4'b1000, 4'b0000, 3'd0, 1'b0, 2'd1, 4'b1100},
    {2'd2, 1'b1, 4'd2,  4'b0000, 4'b1001, 3'd2, 1'b0, 2'd1, 4'b1101},
    {2'd2, 1'b0, 4'd15, 4'b0000, 4'b0000, 3'd0, 1'b1, 2'd0, 4'b0000},
    {2'd0, 1'b1, 4'd15, 4'b0100, 4'b0100, 3'd1, 1'b0, 2'd1, 4'b0100},
    {2'd3, 1'b0, 4'd1,  4'b0010, 4'b0000, 3'd0, 1'b0, 2'd2, 4'b0010},
    {2'd0, 1'b0, 4'd0,  4'b0000, 4'b0000, 3'd0, 1'b1, 2'd0, 4'b0000},
    {2'd0, 1'b0, 4'd2,  4'b0100, 4'b0000, 3'd0, 1'b0, 2'd2, 4'b0100}
  };

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog: got=1 expected=0");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_proc = '0;
    req_write = 1'b0;
    req_blk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: all entries empty after reset; R8: idle outputs quiet
    for (int b = 0; b < 16; b += 5) begin
      req_blk = 4'(b);
      #2;
      chk("R1 state after reset", int'(blk_state), 0);
      chk("R1 holders after reset", int'(blk_sharers), 0);
      chk("R8 idle outputs", int'({fwd_sel, inv_vec, ack_cnt, mem_rd}), 0);
      @(negedge clk);
    end

    // table walk: lookup value plus command vector, entry updates at the following edge
    for (int k = 0; k < NV; k++) begin
      req_valid = 1'b1;
      req_proc  = VEC[k][24:23];
      req_write = VEC[k][22];
      req_blk   = VEC[k][21:18];
      #2;
      chk($sformatf("R4/R7 state row %0d", k), int'(blk_state), int'(VEC[k][5:4]));
      chk($sformatf("R4/R7 holders row %0d", k), int'(blk_sharers), int'(VEC[k][3:0]));
      chk($sformatf("R3/R6 fwd row %0d", k), int'(fwd_sel), int'(VEC[k][17:14]));
      chk($sformatf("R3 fwd_valid row %0d", k), int'(fwd_valid), int'(|VEC[k][17:14]));
      chk($sformatf("R5 inv row %0d", k), int'(inv_vec), int'(VEC[k][13:10]));
      chk($sformatf("R5 ack row %0d", k), int'(ack_cnt), int'(VEC[k][9:7]));
      chk($sformatf("R2/R6 mem row %0d", k), int'(mem_rd), int'(VEC[k][6]));
      @(negedge clk);
    end

    // R8: garbage on request lines with valid low changes nothing
    req_valid = 1'b0;
    req_proc  = 2'd0;
    req_write = 1'b1;
    req_blk   = 4'd2;
    #2;
    chk("R8 idle cmd", int'({fwd_sel, inv_vec, ack_cnt, mem_rd}), 0);
    @(negedge clk);
    #2;
    chk("R8 blk2 state kept", int'(blk_state), 1);
    chk("R8 blk2 holders kept", int'(blk_sharers), 4'b0101);
    req_blk = 4'd15;
    #2;
    chk("R7 blk15 state", int'(blk_state), 2);
    chk("R7 blk15 holders", int'(blk_sharers), 4'b0001);
    req_blk = 4'd0;
    #2;
    chk("R4 blk0 state", int'(blk_state), 1);
    chk("R4 blk0 holders", int'(blk_sharers), 4'b0001);

    // R1: reset mid-run clears entries
    @(negedge clk);
    req_blk = 4'd1;
    #2;
    chk("R4 blk1 before reset", int'(blk_sharers), 4'b1010);
    rst_n = 1'b0;
    #2;
    chk("R1 blk1 state after mid reset", int'(blk_state), 0);
    chk("R1 blk1 holders after mid reset", int'(blk_sharers), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: read after reset goes to memory
    req_valid = 1'b1;
    req_proc  = 2'd3;
    req_write = 1'b0;
    req_blk   = 4'd1;
    #2;
    chk("R2 mem after reset", int'(mem_rd), 1);
    chk("R2 no fwd after reset", int'(fwd_sel), 0);
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    chk("R4 joined after read", int'(blk_sharers), 4'b1000);

    finish_run();
  end

endmodule